// File: doc/BRIEF.md
# Coherent Line Controller with Locked Fetch-and-Add

This block keeps the coherence state of a few cache lines on behalf of one core in a snooping multi-core system. Each line is Modified, Exclusive, Shared or Invalid. Lines are kept consistent with the other cores' caches only by watching their bus traffic. The core side takes loads, stores and fetch-and-add operations. The bus side sends read and read-for-ownership requests. It also answers snoops that other cores' transactions raise.

A fetch-and-add first gains exclusive ownership of its line. If the line is Shared or Invalid, that takes a read-for-ownership. An Exclusive line is promoted silently. The controller then marks the line Modified and sets a lock bit on it. It holds the lock for a fixed number of cycles while it forms the sum. Any snoop to the locked line is told to wait until the new value is committed. Other cores therefore never see the line between the read and the write, and no global bus lock is needed. Each line also holds one data word so that the add has an operand. Memory and the bus arbiter are modelled by the bench.

Top module: `mesi_lock_ctrl`

## Requirements
- R1: After reset every line is Invalid and unlocked. A snoop to any line is acknowledged with hit low, and a load to any line issues a bus request.
- R2: A load to an Invalid line issues a bus read (bus_req_kind 0). When the grant arrives, the line takes the fill word and becomes Shared if bus_fill_shared is 1, else Exclusive. The core then receives the fill word. A load to a valid line issues no bus request and returns the stored word.
- R3: A store or fetch-and-add to a Shared or Invalid line issues a read-for-ownership (bus_req_kind 1). One to an Exclusive or Modified line issues no bus request. In both cases the line ends Modified.
- R4: A fetch-and-add (req_op 2) returns the line's previous word on resp_data. It leaves (old + operand) mod 2^DW in the line, committed ATOM_CYC cycles after the line is owned. A store (req_op 1) returns the previous word and writes req_wdata. A load is req_op 0.
- R5: A snooped read (snp_kind 0) that hits an unlocked line is acknowledged with hit high. The snoop takes the line to Shared. A Modified line also drives snp_dirty high and supplies its word on snp_data.
- R6: A snooped read-for-ownership (snp_kind 1) that hits an unlocked line is acknowledged and makes the line Invalid. A Modified line supplies its word, as in R5.
- R7: A snoop to a locked line holds snp_stall high with snp_ack low in every cycle of the locked sequence. It is acknowledged in the cycle after the lock clears and then sees the committed sum.
- R8: req_ready is low while a request is in progress and while a snoop is presented, so a running atomic takes no new core request.
- R9: A snoop to an Invalid line is acknowledged with hit, dirty and data all zero and leaves the line Invalid.
- R10: A snoop to a line other than the locked one is acknowledged in its first cycle, even during an atomic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_op | input | 2 | 0 load, 1 store, 2 fetch-and-add |
| req_line | input | LW | Line index of the request |
| req_wdata | input | DW | Store word or addend |
| req_ready | output | 1 | Request accepted at this edge if valid |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_data | output | DW | Word held by the line before the operation |
| bus_req_valid | output | 1 | Bus request outstanding |
| bus_req_kind | output | 1 | 0 read, 1 read-for-ownership |
| bus_req_line | output | LW | Line of the bus request |
| bus_gnt | input | 1 | Bus request granted, fill valid |
| bus_fill_data | input | DW | Word returned with the grant |
| bus_fill_shared | input | 1 | Another cache keeps a copy |
| snp_valid | input | 1 | Snoop presented, held until acknowledged |
| snp_kind | input | 1 | 0 read, 1 read-for-ownership |
| snp_line | input | LW | Line of the snoop |
| snp_stall | output | 1 | Snoop must wait, line is locked |
| snp_ack | output | 1 | Snoop answered this cycle |
| snp_hit | output | 1 | Line valid at the snoop |
| snp_dirty | output | 1 | Line was Modified, data supplied |
| snp_data | output | DW | Supplied word |

## Verification
The hardest case to reach is a snoop that arrives while the lock is held. Only a fixed, short window lies between the accepted fetch-and-add and its commit. The bench presents the fetch-and-add on an owned line so that no bus delay occurs. It raises the snoop on the falling edge just after the accepting edge, then counts stall cycles until the acknowledge. It checks that the supplied word is the sum and not the old value. The same sequence, with the snoop aimed at a different line, shows that unrelated lines are still answered at once.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FADD  = 2'd2,
    OP_RSVD  = 2'd3
  } core_op_t;

  // State left behind after another core's snoop is answered.
  function automatic mesi_t snoop_next(input mesi_t cur, input logic is_rfo);
    if (cur == ST_I) return ST_I;
    return is_rfo ? ST_I : ST_S;
  endfunction

  // State taken by a line filled by a plain bus read.
  function automatic mesi_t fill_state(input logic others_share);
    return others_share ? ST_S : ST_E;
  endfunction

  // Writing needs an ownership request unless the copy is already exclusive.
  function automatic logic needs_rfo(input mesi_t cur);
    return (cur == ST_S) || (cur == ST_I);
  endfunction

endpackage

// File: rtl/mlc_snoop_port.sv
module mlc_snoop_port
  import mlc_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int DW     = 8,
  parameter int LW     = 2
) (
  input  logic                        snp_valid,
  input  logic                        snp_kind,
  input  logic [LW-1:0]               snp_line,
  input  mesi_t [NLINES-1:0]          st_q,
  input  logic  [NLINES-1:0]          lock_q,
  input  logic  [NLINES-1:0][DW-1:0]  data_q,
  output logic                        snp_stall,
  output logic                        snp_ack,
  output logic                        snp_hit,
  output logic                        snp_dirty,
  output logic [DW-1:0]               snp_data,
  output logic                        snp_upd,
  output mesi_t                       snp_new_st
);
  mesi_t cur;
  logic  locked;

  assign cur        = st_q[snp_line];
  assign locked     = lock_q[snp_line];
  assign snp_stall  = snp_valid && locked;
  assign snp_ack    = snp_valid && !locked;
  assign snp_hit    = snp_ack && (cur != ST_I);
  assign snp_dirty  = snp_ack && (cur == ST_M);
  assign snp_data   = snp_dirty ? data_q[snp_line] : '0;
  assign snp_upd    = snp_hit;
  assign snp_new_st = snoop_next(cur, snp_kind);
endmodule

// File: rtl/mlc_core_fsm.sv
module mlc_core_fsm
  import mlc_pkg::*;
#(
  parameter int NLINES   = 4,
  parameter int DW       = 8,
  parameter int LW       = 2,
  parameter int ATOM_CYC = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [1:0]                 req_op,
  input  logic [LW-1:0]              req_line,
  input  logic [DW-1:0]              req_wdata,
  output logic                       req_ready,
  output logic                       resp_valid,
  output logic [DW-1:0]              resp_data,
  input  logic                       snp_valid,
  input  mesi_t [NLINES-1:0]         st_q,
  input  logic [NLINES-1:0][DW-1:0]  data_q,
  output logic                       bus_req_valid,
  output logic                       bus_req_kind,
  output logic [LW-1:0]              bus_req_line,
  input  logic                       bus_gnt,
  input  logic [DW-1:0]              bus_fill_data,
  input  logic                       bus_fill_shared,
  output logic                       wr_en,
  output logic [LW-1:0]              wr_line,
  output mesi_t                      wr_st,
  output logic [DW-1:0]              wr_data,
  output logic                       lock_set,
  output logic                       lock_clr,
  output logic                       atomic_busy
);
  localparam int CW = $clog2(ATOM_CYC + 1);

  typedef enum logic [1:0] {F_IDLE, F_BUS, F_ATOM} fsm_t;

  function automatic logic [DW-1:0] fetch_add_sum(input logic [DW-1:0] a,
                                                  input logic [DW-1:0] b);
    return a + b;
  endfunction

  fsm_t          fsm_q;
  core_op_t      op_q, op_in;
  logic [LW-1:0] line_q;
  logic [DW-1:0] wdata_q, old_q;
  logic [CW-1:0] cnt_q;
  logic          accept, hit_ok, atom_last;
  mesi_t         cur;

  assign op_in       = core_op_t'(req_op);
  assign cur         = st_q[req_line];
  assign req_ready   = (fsm_q == F_IDLE) && !snp_valid;
  assign accept      = req_valid && req_ready;
  assign hit_ok      = (op_in == OP_STORE || op_in == OP_FADD) ? !needs_rfo(cur)
                                                              : (cur != ST_I);
  assign atom_last   = (cnt_q == CW'(ATOM_CYC - 1));
  assign atomic_busy = (fsm_q == F_ATOM);

  assign bus_req_valid = (fsm_q == F_BUS);
  assign bus_req_kind  = (op_q != OP_LOAD);
  assign bus_req_line  = line_q;

  always_comb begin
    wr_en    = 1'b0;
    wr_line  = line_q;
    wr_st    = ST_M;
    wr_data  = '0;
    lock_set = 1'b0;
    lock_clr = 1'b0;
    case (fsm_q)
      F_IDLE: begin
        wr_line = req_line;
        if (accept && hit_ok) begin
          if (op_in == OP_STORE) begin
            wr_en   = 1'b1;
            wr_data = req_wdata;
          end else if (op_in == OP_FADD) begin
            wr_en    = 1'b1;
            wr_data  = data_q[req_line];
            lock_set = 1'b1;
          end
        end
      end
      F_BUS: begin
        if (bus_gnt) begin
          wr_en = 1'b1;
          if (op_q == OP_STORE) begin
            wr_data = wdata_q;
          end else if (op_q == OP_FADD) begin
            wr_data  = bus_fill_data;
            lock_set = 1'b1;
          end else begin
            wr_st   = fill_state(bus_fill_shared);
            wr_data = bus_fill_data;
          end
        end
      end
      F_ATOM: begin
        if (atom_last) begin
          wr_en    = 1'b1;
          wr_data  = fetch_add_sum(old_q, wdata_q);
          lock_clr = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q      <= F_IDLE;
      op_q       <= OP_LOAD;
      line_q     <= '0;
      wdata_q    <= '0;
      old_q      <= '0;
      cnt_q      <= '0;
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (fsm_q)
        F_IDLE: begin
          if (accept) begin
            op_q    <= op_in;
            line_q  <= req_line;
            wdata_q <= req_wdata;
            if (!hit_ok) begin
              fsm_q <= F_BUS;
            end else if (op_in == OP_FADD) begin
              fsm_q <= F_ATOM;
              old_q <= data_q[req_line];
              cnt_q <= '0;
            end else begin
              resp_valid <= 1'b1;
              resp_data  <= data_q[req_line];
            end
          end
        end
        F_BUS: begin
          if (bus_gnt) begin
            if (op_q == OP_FADD) begin
              fsm_q <= F_ATOM;
              old_q <= bus_fill_data;
              cnt_q <= '0;
            end else begin
              fsm_q      <= F_IDLE;
              resp_valid <= 1'b1;
              resp_data  <= bus_fill_data;
            end
          end
        end
        F_ATOM: begin
          cnt_q <= cnt_q + 1'b1;
          if (atom_last) begin
            fsm_q      <= F_IDLE;
            resp_valid <= 1'b1;
            resp_data  <= old_q;
          end
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mlc_line_store.sv
module mlc_line_store
  import mlc_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int DW     = 8,
  parameter int LW     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       snp_upd,
  input  logic [LW-1:0]              snp_line,
  input  mesi_t                      snp_new_st,
  input  logic                       wr_en,
  input  logic [LW-1:0]              wr_line,
  input  mesi_t                      wr_st,
  input  logic [DW-1:0]              wr_data,
  input  logic                       lock_set,
  input  logic                       lock_clr,
  output mesi_t [NLINES-1:0]         st_q,
  output logic [NLINES-1:0]          lock_q,
  output logic [NLINES-1:0][DW-1:0]  data_q
);
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic sel_snp, sel_wr;
    assign sel_snp = snp_upd && (snp_line == LW'(g));
    assign sel_wr  = (wr_line == LW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= ST_I;
        lock_q[g] <= 1'b0;
        data_q[g] <= '0;
      end else begin
        if (sel_snp) st_q[g] <= snp_new_st;
        if (wr_en && sel_wr) begin
          st_q[g]   <= wr_st;
          data_q[g] <= wr_data;
        end
        if (lock_set && sel_wr)      lock_q[g] <= 1'b1;
        else if (lock_clr && sel_wr) lock_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mesi_lock_ctrl.sv
module mesi_lock_ctrl
  import mlc_pkg::*;
#(
  parameter int NLINES   = 4,
  parameter int DW       = 8,
  parameter int ATOM_CYC = 3,
  localparam int LW      = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [LW-1:0] req_line,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data,
  output logic          bus_req_valid,
  output logic          bus_req_kind,
  output logic [LW-1:0] bus_req_line,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_fill_data,
  input  logic          bus_fill_shared,
  input  logic          snp_valid,
  input  logic          snp_kind,
  input  logic [LW-1:0] snp_line,
  output logic          snp_stall,
  output logic          snp_ack,
  output logic          snp_hit,
  output logic          snp_dirty,
  output logic [DW-1:0] snp_data
);
  mesi_t [NLINES-1:0]         st_q;
  logic  [NLINES-1:0]         lock_q;
  logic  [NLINES-1:0][DW-1:0] data_q;
  logic                       snp_upd;
  mesi_t                      snp_new_st;
  logic                       wr_en, lock_set, lock_clr, atomic_busy;
  logic  [LW-1:0]             wr_line;
  mesi_t                      wr_st;
  logic  [DW-1:0]             wr_data;

  mlc_snoop_port #(.NLINES(NLINES), .DW(DW), .LW(LW)) u_snoop (
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_line(snp_line),
    .st_q(st_q), .lock_q(lock_q), .data_q(data_q),
    .snp_stall(snp_stall), .snp_ack(snp_ack), .snp_hit(snp_hit),
    .snp_dirty(snp_dirty), .snp_data(snp_data),
    .snp_upd(snp_upd), .snp_new_st(snp_new_st)
  );

  mlc_core_fsm #(.NLINES(NLINES), .DW(DW), .LW(LW), .ATOM_CYC(ATOM_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_line(req_line),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_data(resp_data),
    .snp_valid(snp_valid), .st_q(st_q), .data_q(data_q),
    .bus_req_valid(bus_req_valid), .bus_req_kind(bus_req_kind),
    .bus_req_line(bus_req_line), .bus_gnt(bus_gnt),
    .bus_fill_data(bus_fill_data), .bus_fill_shared(bus_fill_shared),
    .wr_en(wr_en), .wr_line(wr_line), .wr_st(wr_st), .wr_data(wr_data),
    .lock_set(lock_set), .lock_clr(lock_clr), .atomic_busy(atomic_busy)
  );

  mlc_line_store #(.NLINES(NLINES), .DW(DW), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .snp_upd(snp_upd), .snp_line(snp_line), .snp_new_st(snp_new_st),
    .wr_en(wr_en), .wr_line(wr_line), .wr_st(wr_st), .wr_data(wr_data),
    .lock_set(lock_set), .lock_clr(lock_clr),
    .st_q(st_q), .lock_q(lock_q), .data_q(data_q)
  );
endmodule

// File: rtl/mlc_checker.sv
module mlc_checker
  import mlc_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int LW     = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                snp_valid,
  input logic [LW-1:0]       snp_line,
  input logic                snp_stall,
  input logic                snp_ack,
  input mesi_t [NLINES-1:0]  st_q,
  input logic [NLINES-1:0]   lock_q,
  input logic                atomic_busy,
  input logic                req_ready,
  input logic                bus_req_valid
);
  logic [NLINES-1:0] m_mask;
  always_comb begin
    for (int i = 0; i < NLINES; i++) m_mask[i] = (st_q[i] == ST_M);
  end

  AST_LOCKED_SNOOP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && lock_q[snp_line] |-> snp_stall && !snp_ack); // R7
  AST_LOCK_ONLY_ON_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q & ~m_mask) == '0); // R4
  AST_SINGLE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_q)); // R8
  AST_LOCK_TRACKS_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != '0) == atomic_busy); // R4
  AST_ATOMIC_BLOCKS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    atomic_busy |-> !req_ready); // R8
  AST_ATOMIC_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    atomic_busy |-> !bus_req_valid); // R3
  AST_STALL_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_stall && snp_ack)); // R7
endmodule

bind mesi_lock_ctrl mlc_checker #(.NLINES(NLINES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_line(snp_line),
  .snp_stall(snp_stall), .snp_ack(snp_ack), .st_q(st_q), .lock_q(lock_q),
  .atomic_busy(atomic_busy), .req_ready(req_ready), .bus_req_valid(bus_req_valid)
);

// File: tb/tb_mesi_lock_ctrl.sv
module tb_mesi_lock_ctrl;
  localparam int NL = 4;
  localparam int DW = 8;
  localparam int AC = 3;
  localparam int LW = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [LW-1:0] req_line = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, resp_valid;
  logic [DW-1:0] resp_data;
  logic bus_req_valid, bus_req_kind;
  logic [LW-1:0] bus_req_line;
  logic bus_gnt = 1'b0;
  logic [DW-1:0] bus_fill_data = '0;
  logic bus_fill_shared = 1'b0;
  logic snp_valid = 1'b0;
  logic snp_kind = 1'b0;
  logic [LW-1:0] snp_line = '0;
  logic snp_stall, snp_ack, snp_hit, snp_dirty;
  logic [DW-1:0] snp_data;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mesi_lock_ctrl #(.NLINES(NL), .DW(DW), .ATOM_CYC(AC)) dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic core_op(input int op, input int line, input logic [DW-1:0] wd,
                         input logic [DW-1:0] fill, input logic shr,
                         output logic [DW-1:0] rdata, output bit bus_used,
                         output logic bus_kind, output bit busy_ok);
    bus_used = 0; bus_kind = 0; busy_ok = 1; rdata = '0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_line = LW'(line); req_wdata = wd;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      #1;
      if (resp_valid) begin rdata = resp_data; break; end
      if (req_ready) busy_ok = 0;
      if (bus_req_valid) begin
        bus_used = 1; bus_kind = bus_req_kind;
        bus_gnt = 1'b1; bus_fill_data = fill; bus_fill_shared = shr;
      end
      @(negedge clk);
      bus_gnt = 1'b0;
    end
  endtask

  task automatic snoop(input logic kind, input int line, output logic hit,
                       output logic dirty, output logic [DW-1:0] sdata,
                       output int stalls, output logic rdy_seen);
    stalls = 0; hit = 0; dirty = 0; sdata = '0;
    @(negedge clk);
    snp_valid = 1'b1; snp_kind = kind; snp_line = LW'(line);
    #1;
    rdy_seen = req_ready;
    while (!snp_ack) begin
      if (snp_stall) stalls++;
      @(negedge clk); #1;
    end
    hit = snp_hit; dirty = snp_dirty; sdata = snp_data;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic fadd_snoop(input int line, input logic [DW-1:0] add,
                            input int sline, input logic skind,
                            output int stalls, output logic hit, output logic dirty,
                            output logic [DW-1:0] sdata, output logic [DW-1:0] rdata);
    bit got_ack = 0;
    bit got_resp = 0;
    stalls = 0; hit = 0; dirty = 0; sdata = '0; rdata = '0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd2; req_line = LW'(line); req_wdata = add;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; snp_valid = 1'b1; snp_kind = skind; snp_line = LW'(sline);
    while (!(got_ack && got_resp)) begin
      #1;
      if (resp_valid) begin got_resp = 1; rdata = resp_data; end
      if (!got_ack) begin
        if (snp_ack) begin
          got_ack = 1; hit = snp_hit; dirty = snp_dirty; sdata = snp_data;
        end else if (snp_stall) stalls++;
      end
      @(negedge clk);
      if (got_ack) snp_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd, sd, expv;
    bit bu, bok;
    logic bk, h, d, rdy;
    int st;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 / R9: every line starts Invalid
    for (int l = 0; l < NL; l++) begin
      snoop(1'b0, l, h, d, sd, st, rdy);
      chk("R1", "reset snoop hit", int'(h), 0);
      chk("R9", "invalid snoop dirty", int'(d), 0);
      chk("R8", "ready low during snoop", int'(rdy), 0);
    end

    // R1 / R2: load miss, exclusive fill
    core_op(0, 0, 8'h00, 8'h11, 1'b0, rd, bu, bk, bok);
    chk("R1", "load after reset uses bus", int'(bu), 1);
    chk("R2", "bus kind read", int'(bk), 0);
    chk("R2", "load miss data", int'(rd), 'h11);
    chk("R8", "ready low while bus pending", int'(bok), 1);
    // R3: store on Exclusive is silent
    core_op(1, 0, 8'h22, 8'h00, 1'b0, rd, bu, bk, bok);
    chk("R3", "store on E no bus", int'(bu), 0);
    chk("R4", "store returns old word", int'(rd), 'h11);
    // R5: snoop read on Modified supplies data
    snoop(1'b0, 0, h, d, sd, st, rdy);
    chk("R5", "snoop M hit", int'(h), 1);
    chk("R5", "snoop M dirty", int'(d), 1);
    chk("R5", "snoop M data", int'(sd), 'h22);
    // R3: store on Shared needs ownership
    core_op(1, 0, 8'h33, 8'h22, 1'b0, rd, bu, bk, bok);
    chk("R3", "store on S uses bus", int'(bu), 1);
    chk("R3", "store on S is RFO", int'(bk), 1);
    chk("R4", "store RFO returns fill", int'(rd), 'h22);
    // R6: snooped RFO invalidates
    snoop(1'b1, 0, h, d, sd, st, rdy);
    chk("R6", "rfo snoop dirty", int'(d), 1);
    chk("R6", "rfo snoop data", int'(sd), 'h33);
    snoop(1'b0, 0, h, d, sd, st, rdy);
    chk("R6", "line invalid after rfo snoop", int'(h), 0);

    // R2: shared fill, R5 shared stays clean
    core_op(0, 1, 8'h00, 8'h40, 1'b1, rd, bu, bk, bok);
    chk("R2", "shared fill data", int'(rd), 'h40);
    snoop(1'b0, 1, h, d, sd, st, rdy);
    chk("R5", "snoop S hit", int'(h), 1);
    chk("R5", "snoop S clean", int'(d), 0);
    // R3 / R4: fetch-and-add on Shared
    core_op(2, 1, 8'h05, 8'h40, 1'b0, rd, bu, bk, bok);
    chk("R3", "fadd on S is RFO", int'(bk), 1);
    chk("R4", "fadd returns old", int'(rd), 'h40);
    chk("R8", "ready low during atomic", int'(bok), 1);
    core_op(0, 1, 8'h00, 8'h00, 1'b0, rd, bu, bk, bok);
    chk("R2", "load hit no bus", int'(bu), 0);
    chk("R4", "sum committed", int'(rd), 'h45);

    // R7: snoop during locked sequence
    fadd_snoop(1, 8'h10, 1, 1'b0, st, h, d, sd, rd);
    chk("R7", "stall cycles", st, AC);
    chk("R7", "post-lock dirty", int'(d), 1);
    chk("R7", "post-lock data is sum", int'(sd), 'h55);
    chk("R4", "locked fadd old", int'(rd), 'h45);
    snoop(1'b0, 1, h, d, sd, st, rdy);
    chk("R5", "line shared after read snoop", int'(d), 0);

    // R5: E goes to S on snoop read; store then needs RFO
    core_op(0, 2, 8'h00, 8'h70, 1'b0, rd, bu, bk, bok);
    snoop(1'b0, 2, h, d, sd, st, rdy);
    chk("R5", "snoop E hit", int'(h), 1);
    chk("R5", "snoop E clean", int'(d), 0);
    core_op(1, 2, 8'h70, 8'h70, 1'b0, rd, bu, bk, bok);
    chk("R5", "E demoted to S needs RFO", int'(bk), 1);
    // R10: other line answered during atomic
    fadd_snoop(2, 8'h01, 1, 1'b0, st, h, d, sd, rd);
    chk("R10", "no stall on other line", st, 0);
    chk("R10", "other line hit", int'(h), 1);
    chk("R4", "fadd line2 old", int'(rd), 'h70);
    snoop(1'b1, 2, h, d, sd, st, rdy);
    chk("R6", "rfo snoop after fadd", int'(sd), 'h71);

    // R4 sweep with wraparound, every line
    for (int l = 0; l < NL; l++) begin
      for (int vi = 0; vi < 6; vi++) begin
        for (int ai = 0; ai < 4; ai++) begin
          logic [DW-1:0] v, a;
          case (vi)
            0: v = 8'h00; 1: v = 8'h01; 2: v = 8'h7f;
            3: v = 8'h80; 4: v = 8'hfe; default: v = 8'hff;
          endcase
          case (ai)
            0: a = 8'h00; 1: a = 8'h01; 2: a = 8'h80; default: a = 8'hff;
          endcase
          expv = DW'((int'(v) + int'(a)) % 256);
          core_op(1, l, v, 8'h5a, 1'b0, rd, bu, bk, bok);
          core_op(2, l, a, 8'h00, 1'b0, rd, bu, bk, bok);
          chk("R4", "sweep fadd old", int'(rd), int'(v));
          chk("R3", "sweep fadd on M silent", int'(bu), 0);
          core_op(0, l, 8'h00, 8'h00, 1'b0, rd, bu, bk, bok);
          chk("R4", "sweep sum", int'(rd), int'(expv));
        end
      end
    end

    // R7 with a read-for-ownership snoop against the lock
    fadd_snoop(3, 8'h02, 3, 1'b1, st, h, d, sd, rd);
    expv = DW'((int'(8'hfe) + 2) % 256);
    chk("R7", "rfo stall cycles", st, AC);
    chk("R7", "rfo sees sum", int'(sd), int'(expv));
    snoop(1'b0, 3, h, d, sd, st, rdy);
    chk("R6", "invalid after locked rfo", int'(h), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule